// File: doc/BRIEF.md
# Super I/O Resource Decoder

This block turns the raw configuration bytes of a multi-function I/O controller into the resource assignments of its four built-in functions. The functions are a floppy disk controller, two serial ports and a parallel port. For each function it derives an enable, a 10-bit I/O base address, an interrupt line selector and, where one applies, a DMA channel or a baud clock selection. Each base is a configuration byte shifted left by two, so every window starts on a 4-byte boundary within the first 1 KiB of I/O space.

It also decodes host I/O cycles. When the address strobe is valid, the host address is compared against every enabled window. At most one chip select is raised, following a fixed priority. All outputs are registered and appear one clock after their inputs. The internals of the functions themselves live elsewhere.

Top module: `sio_res_decoder`

## Requirements
- R1: The floppy function is enabled when bits 7:6 of `cfg_fdc_win` are not both zero. Its base is `{cfg_fdc_win[7:2], 2'b00, 2'b00}`, meaning the byte with its bits 1:0 forced to zero and then shifted left by two.
- R2: Serial port n (n = 0, 1) takes its base from `cfg_sp_win[n]` with bit 0 forced to zero, shifted left by two. The port is enabled only when its power bit in `cfg_sp_pwr` is set and bits 7:6 of its base byte are not both zero. The power bit is bit 3 for port 0 and bit 7 for port 1.
- R3: The interrupt selector of serial port 0 is `cfg_sp_irq[7:4]`, and that of port 1 is `cfg_sp_irq[3:0]`.
- R4: The parallel port is enabled when `cfg_par_ctl[2]` is set and `cfg_par_win` is at least 0x40. Its base is `cfg_par_win` shifted left by two, with bit 0 of the byte cleared first when `cfg_mode[0]` is set.
- R5: The floppy interrupt selector is `cfg_irq[7:4]` and the parallel interrupt selector is `cfg_irq[3:0]`. The floppy DMA channel is `cfg_dma[7:4]`.
- R6: The clock code of serial port n is `{cfg_clk_ext[6+n], cfg_mode[4+n]}`. Its divisor output of the 24 MHz clock is 13 for code 0, 12 for code 1, and 3 for codes 2 and 3.
- R7: A chip select can only be raised while `io_valid` is high, and only for an enabled function whose window holds `io_addr`. Each window starts at the function's base. The floppy window and each serial window are 8 bytes wide. The parallel window is 4 bytes wide, or 8 bytes when `cfg_mode[1:0]` is nonzero. Address bits above bit 9 must be zero for any hit.
- R8: Where enabled windows overlap, the floppy wins first, then serial port 0, then serial port 1, then the parallel port, so at most one chip select is high.
- R9: Every output is registered and reflects the inputs of the preceding clock edge. While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_par_ctl | input | 8 | Control byte; bit 2 turns the parallel port on |
| cfg_sp_pwr | input | 8 | Power byte; bits 3 and 7 power serial ports 0 and 1 |
| cfg_mode | input | 8 | Mode byte: parallel span and alignment (1:0), serial clock low bits (5:4) |
| cfg_clk_ext | input | 8 | Clock byte; bits 7:6 are serial clock high bits |
| cfg_fdc_win | input | 8 | Floppy base byte |
| cfg_par_win | input | 8 | Parallel base byte |
| cfg_sp_win | input | 2x8 | Serial base bytes, index = port |
| cfg_dma | input | 8 | DMA byte; high nibble is the floppy channel |
| cfg_irq | input | 8 | Interrupt byte: floppy (7:4), parallel (3:0) |
| cfg_sp_irq | input | 8 | Serial interrupt byte: port 0 (7:4), port 1 (3:0) |
| io_addr | input | ADDR_W | Host I/O address |
| io_valid | input | 1 | Host address strobe |
| fdc_en | output | 1 | Floppy enabled |
| fdc_base | output | 10 | Floppy base address |
| fdc_irq | output | 4 | Floppy interrupt selector |
| fdc_dma | output | 4 | Floppy DMA channel |
| sp_en | output | 2 | Serial enables, index = port |
| sp_base | output | 2x10 | Serial base addresses |
| sp_irq | output | 2x4 | Serial interrupt selectors |
| sp_clk | output | 2x2 | Serial clock codes |
| sp_div | output | 2x4 | Serial clock divisors |
| par_en | output | 1 | Parallel enabled |
| par_base | output | 10 | Parallel base address |
| par_irq | output | 4 | Parallel interrupt selector |
| cs_fdc | output | 1 | Floppy chip select |
| cs_sp | output | 2 | Serial chip selects |
| cs_par | output | 1 | Parallel chip select |

## Verification
The bench uses the default parameters: a 16-bit host address and window spans of 8, 8, 4 and 8 bytes. With these spans, the stimulus reaches both edges of each window (the base and the last byte) and the first byte past it. It also reaches addresses whose bits above bit 9 are set. Directed cases place the parallel byte at 0x3F and at 0x40. They stack the floppy, serial and parallel windows on one base to exercise the priority, and switch the parallel window between its 4-byte and 8-byte spans.

// File: rtl/sio_dec_pkg.sv
package sio_dec_pkg;
    localparam int BASE_W = 10;
    localparam int NSP    = 2;
    localparam int NIB    = 4;

    typedef struct packed {
        logic              en;
        logic [BASE_W-1:0] base;
        logic [NIB-1:0]    irq;
    } dev_cfg_t;

    // Divisor of the 24 MHz reference for a serial clock code
    function automatic logic [3:0] clk_divisor(input logic [1:0] code);
        case (code)
            2'd0:    clk_divisor = 4'd13;
            2'd1:    clk_divisor = 4'd12;
            default: clk_divisor = 4'd3;
        endcase
    endfunction
endpackage

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
    import sio_dec_pkg::*;
(
    input  logic [7:0]          cfg_par_ctl,
    input  logic [7:0]          cfg_sp_pwr,
    input  logic [7:0]          cfg_mode,
    input  logic [7:0]          cfg_clk_ext,
    input  logic [7:0]          cfg_fdc_win,
    input  logic [7:0]          cfg_par_win,
    input  logic [NSP-1:0][7:0] cfg_sp_win,
    input  logic [7:0]          cfg_irq,
    input  logic [7:0]          cfg_sp_irq,
    output dev_cfg_t            fdc,
    output dev_cfg_t [NSP-1:0]  sp,
    output logic [NSP-1:0][1:0] sp_clk,
    output dev_cfg_t            par,
    output logic                par_wide
);
    logic [7:0] par_byte;

    always_comb begin
        fdc.en   = |cfg_fdc_win[7:6];
        fdc.base = {cfg_fdc_win[7:2], 2'b00, 2'b00};
        fdc.irq  = cfg_irq[7:4];

        par_byte = cfg_mode[0] ? {cfg_par_win[7:1], 1'b0} : cfg_par_win;
        par.en   = cfg_par_ctl[2] && (cfg_par_win >= 8'h40);
        par.base = {par_byte, 2'b00};
        par.irq  = cfg_irq[3:0];
        par_wide = |cfg_mode[1:0];
    end

    for (genvar n = 0; n < NSP; n++) begin : g_sp
        always_comb begin
            sp[n].en   = cfg_sp_pwr[3 + 4*n] && (|cfg_sp_win[n][7:6]);
            sp[n].base = {cfg_sp_win[n][7:1], 1'b0, 2'b00};
            sp[n].irq  = cfg_sp_irq[7 - 4*n -: 4];
            sp_clk[n]  = {cfg_clk_ext[6 + n], cfg_mode[4 + n]};
        end
    end
endmodule

// File: rtl/sio_win_match.sv
module sio_win_match #(
    parameter int ADDR_W = 16,
    parameter int BASE_W = 10,
    parameter int SPAN_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    input  logic [SPAN_W-1:0] span,
    input  logic              en,
    output logic              hit
);
    logic [BASE_W:0] diff;
    logic            hi_zero;

    always_comb begin
        hi_zero = (addr[ADDR_W-1:BASE_W] == '0);
        diff    = {1'b0, addr[BASE_W-1:0]} - {1'b0, base};
        hit     = en && hi_zero && !diff[BASE_W]
                  && (diff < (BASE_W+1)'(span));
    end
endmodule

// File: rtl/sio_res_decoder.sv
module sio_res_decoder
    import sio_dec_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int FDC_SPAN  = 8,
    parameter int SP_SPAN   = 8,
    parameter int PAR_SPAN  = 4,
    parameter int PAR_XSPAN = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              cfg_par_ctl,
    input  logic [7:0]              cfg_sp_pwr,
    input  logic [7:0]              cfg_mode,
    input  logic [7:0]              cfg_clk_ext,
    input  logic [7:0]              cfg_fdc_win,
    input  logic [7:0]              cfg_par_win,
    input  logic [1:0][7:0]         cfg_sp_win,
    input  logic [7:0]              cfg_dma,
    input  logic [7:0]              cfg_irq,
    input  logic [7:0]              cfg_sp_irq,
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic                    io_valid,
    output logic                    fdc_en,
    output logic [9:0]              fdc_base,
    output logic [3:0]              fdc_irq,
    output logic [3:0]              fdc_dma,
    output logic [1:0]              sp_en,
    output logic [1:0][9:0]         sp_base,
    output logic [1:0][3:0]         sp_irq,
    output logic [1:0][1:0]         sp_clk,
    output logic [1:0][3:0]         sp_div,
    output logic                    par_en,
    output logic [9:0]              par_base,
    output logic [3:0]              par_irq,
    output logic                    cs_fdc,
    output logic [1:0]              cs_sp,
    output logic                    cs_par
);
    localparam int MAX_SPAN = (FDC_SPAN > SP_SPAN)
                            ? ((FDC_SPAN > PAR_XSPAN) ? FDC_SPAN : PAR_XSPAN)
                            : ((SP_SPAN > PAR_XSPAN) ? SP_SPAN : PAR_XSPAN);
    localparam int SPAN_W   = $clog2(MAX_SPAN + 1);

    typedef struct packed {
        dev_cfg_t            fdc;
        logic [3:0]          dma;
        dev_cfg_t [NSP-1:0]  sp;
        logic [NSP-1:0][1:0] clk;
        logic [NSP-1:0][3:0] div;
        dev_cfg_t            par;
        logic                cs_f;
        logic [NSP-1:0]      cs_s;
        logic                cs_p;
    } state_t;

    state_t              st_d, st_q;
    dev_cfg_t            fdc_c, par_c;
    dev_cfg_t [NSP-1:0]  sp_c;
    logic [NSP-1:0][1:0] clk_c;
    logic                par_wide;
    logic                hit_f, hit_p;
    logic [NSP-1:0]      hit_s;
    logic [SPAN_W-1:0]   par_span;

    sio_cfg_decode u_cfg (
        .cfg_par_ctl (cfg_par_ctl),
        .cfg_sp_pwr  (cfg_sp_pwr),
        .cfg_mode    (cfg_mode),
        .cfg_clk_ext (cfg_clk_ext),
        .cfg_fdc_win (cfg_fdc_win),
        .cfg_par_win (cfg_par_win),
        .cfg_sp_win  (cfg_sp_win),
        .cfg_irq     (cfg_irq),
        .cfg_sp_irq  (cfg_sp_irq),
        .fdc         (fdc_c),
        .sp          (sp_c),
        .sp_clk      (clk_c),
        .par         (par_c),
        .par_wide    (par_wide)
    );

    assign par_span = par_wide ? SPAN_W'(PAR_XSPAN) : SPAN_W'(PAR_SPAN);

    sio_win_match #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .SPAN_W(SPAN_W)) u_win_fdc (
        .addr (io_addr), .base (fdc_c.base), .span (SPAN_W'(FDC_SPAN)),
        .en (fdc_c.en), .hit (hit_f)
    );

    for (genvar n = 0; n < NSP; n++) begin : g_win_sp
        sio_win_match #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .SPAN_W(SPAN_W)) u_win (
            .addr (io_addr), .base (sp_c[n].base), .span (SPAN_W'(SP_SPAN)),
            .en (sp_c[n].en), .hit (hit_s[n])
        );
    end

    sio_win_match #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .SPAN_W(SPAN_W)) u_win_par (
        .addr (io_addr), .base (par_c.base), .span (par_span),
        .en (par_c.en), .hit (hit_p)
    );

    always_comb begin
        st_d     = '0;
        st_d.fdc = fdc_c;
        st_d.dma = cfg_dma[7:4];
        st_d.sp  = sp_c;
        st_d.clk = clk_c;
        for (int n = 0; n < NSP; n++) st_d.div[n] = clk_divisor(clk_c[n]);
        st_d.par = par_c;
        if (io_valid) begin
            if (hit_f)         st_d.cs_f    = 1'b1;
            else if (hit_s[0]) st_d.cs_s[0] = 1'b1;
            else if (hit_s[1]) st_d.cs_s[1] = 1'b1;
            else if (hit_p)    st_d.cs_p    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fdc_en   = st_q.fdc.en;
    assign fdc_base = st_q.fdc.base;
    assign fdc_irq  = st_q.fdc.irq;
    assign fdc_dma  = st_q.dma;
    assign par_en   = st_q.par.en;
    assign par_base = st_q.par.base;
    assign par_irq  = st_q.par.irq;
    assign cs_fdc   = st_q.cs_f;
    assign cs_sp    = st_q.cs_s;
    assign cs_par   = st_q.cs_p;
    assign sp_clk   = st_q.clk;
    assign sp_div   = st_q.div;
    for (genvar n = 0; n < NSP; n++) begin : g_out
        assign sp_en[n]   = st_q.sp[n].en;
        assign sp_base[n] = st_q.sp[n].base;
        assign sp_irq[n]  = st_q.sp[n].irq;
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_fdc, cs_sp, cs_par})); // R8
    AST_CS_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !io_valid |=> !(cs_fdc || (|cs_sp) || cs_par)); // R7
    AST_CS_FDC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fdc |-> fdc_en); // R7
    AST_CS_PAR_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_par |-> par_en); // R7
    AST_PAR_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        par_en |-> (par_base[9:8] != 2'b00)); // R4
    AST_FDC_BASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fdc_en |-> (fdc_base[9:8] != 2'b00)); // R1
    AST_SP0_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sp_pwr[3] |=> !sp_en[0]); // R2
    AST_SP1_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sp_pwr[7] |=> !sp_en[1]); // R2
    AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sp_div[0] == 4'd13 || sp_div[0] == 4'd12 || sp_div[0] == 4'd3)); // R6
endmodule

// File: tb/sio_res_decoder_test.sv
module sio_res_decoder_test;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      cfg_par_ctl = '0, cfg_sp_pwr = '0, cfg_mode = '0, cfg_clk_ext = '0;
    logic [7:0]      cfg_fdc_win = '0, cfg_par_win = '0, cfg_dma = '0, cfg_irq = '0, cfg_sp_irq = '0;
    logic [1:0][7:0] cfg_sp_win = '0;
    logic [15:0]     io_addr = '0;
    logic            io_valid = 1'b0;
    logic            fdc_en, par_en, cs_fdc, cs_par;
    logic [9:0]      fdc_base, par_base;
    logic [3:0]      fdc_irq, fdc_dma, par_irq;
    logic [1:0]      sp_en, cs_sp;
    logic [1:0][9:0] sp_base;
    logic [1:0][3:0] sp_irq, sp_div;
    logic [1:0][1:0] sp_clk;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sio_res_decoder uut (.*);

    task automatic check(input string req, input int got, input int exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic bit win(input int a, input int b, input int sz, input bit en);
        return en && a >= b && a < b + sz;
    endfunction

    task automatic apply_and_check();
        bit e_f, e_p;
        bit [1:0] e_s;
        int bf, bp, sz_p, a;
        int bs[2];
        bit [3:0] cs;
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        e_f = cfg_fdc_win[7:6] != 0;
        bf  = {cfg_fdc_win[7:2], 4'b0000};
        check("R1 fdc_en", fdc_en, e_f);
        check("R1 fdc_base", fdc_base, bf);
        for (int n = 0; n < 2; n++) begin
            e_s[n] = cfg_sp_pwr[3 + 4*n] && (cfg_sp_win[n][7:6] != 0);
            bs[n]  = {cfg_sp_win[n][7:1], 3'b000};
            check("R2 sp_en", sp_en[n], e_s[n]);
            check("R2 sp_base", sp_base[n], bs[n]);
            check("R3 sp_irq", sp_irq[n], n == 0 ? cfg_sp_irq[7:4] : cfg_sp_irq[3:0]);
            check("R6 sp_clk", sp_clk[n], {cfg_clk_ext[6+n], cfg_mode[4+n]});
            check("R6 sp_div", sp_div[n],
                  {cfg_clk_ext[6+n], cfg_mode[4+n]} == 0 ? 13 :
                  {cfg_clk_ext[6+n], cfg_mode[4+n]} == 1 ? 12 : 3);
        end
        e_p = cfg_par_ctl[2] && cfg_par_win >= 8'h40;
        bp  = (cfg_mode[0] ? (cfg_par_win & 8'hFE) : cfg_par_win) * 4;
        check("R4 par_en", par_en, e_p);
        check("R4 par_base", par_base, bp);
        check("R5 fdc_irq", fdc_irq, cfg_irq[7:4]);
        check("R5 par_irq", par_irq, cfg_irq[3:0]);
        check("R5 fdc_dma", fdc_dma, cfg_dma[7:4]);
        sz_p = (cfg_mode[1:0] != 0) ? 8 : 4;
        a = io_addr;
        cs = '0;
        if (io_valid) begin
            if (win(a, bf, 8, e_f))               cs = 4'b1000;
            else if (win(a, bs[0], 8, e_s[0]))    cs = 4'b0100;
            else if (win(a, bs[1], 8, e_s[1]))    cs = 4'b0010;
            else if (win(a, bp, sz_p, e_p))       cs = 4'b0001;
        end
        check("R7 R8 chip selects", {cs_fdc, cs_sp[0], cs_sp[1], cs_par}, cs);
    endtask

    initial begin
        int seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset fdc_en", fdc_en, 0);
        check("R9 reset cs", {cs_fdc, cs_sp, cs_par}, 0);
        check("R9 reset sp_div", sp_div, 0);
        rst_n = 1'b1;

        // R4 threshold 0x3F vs 0x40
        cfg_par_ctl = 8'h04; cfg_par_win = 8'h3F; apply_and_check();
        cfg_par_win = 8'h40; apply_and_check();
        cfg_par_ctl = 8'h00; apply_and_check();
        // R4 alignment with mode bit 0
        cfg_par_ctl = 8'h04; cfg_par_win = 8'hDF; cfg_mode = 8'h01; apply_and_check();
        // R8 overlap: all on base 0x3F0
        cfg_fdc_win = 8'hFC; cfg_sp_win[0] = 8'hFC; cfg_sp_win[1] = 8'hFC; cfg_par_win = 8'hFC;
        cfg_sp_pwr = 8'h88; cfg_mode = 8'h00; io_valid = 1'b1; io_addr = 16'h03F4; apply_and_check();
        cfg_fdc_win = 8'h00; apply_and_check();
        cfg_sp_pwr = 8'h80; apply_and_check();
        cfg_sp_pwr = 8'h00; apply_and_check();
        // R7 parallel span 4 vs 8
        io_addr = 16'h03F6; apply_and_check();
        cfg_mode = 8'h02; apply_and_check();
        io_addr = 16'h03F8; apply_and_check();
        // R7 high address bits and no strobe
        io_addr = 16'h13F4; apply_and_check();
        io_addr = 16'h03F4; io_valid = 1'b0; apply_and_check();
        // R2 power bit off with a valid base
        cfg_sp_win[0] = 8'hC0; cfg_sp_pwr = 8'h80; io_valid = 1'b1; io_addr = 16'h0300; apply_and_check();

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            logic [7:0] r[2];
            int pick;
            cfg_par_ctl = 8'($urandom); cfg_sp_pwr = 8'($urandom);
            cfg_mode = 8'($urandom); cfg_clk_ext = 8'($urandom);
            cfg_fdc_win = 8'($urandom); cfg_par_win = 8'($urandom);
            cfg_sp_win[0] = 8'($urandom); cfg_sp_win[1] = 8'($urandom);
            cfg_dma = 8'($urandom); cfg_irq = 8'($urandom); cfg_sp_irq = 8'($urandom);
            r[0] = cfg_fdc_win; r[1] = cfg_par_win;
            pick = $urandom_range(0, 4);
            case (pick)
                0: io_addr = 16'(int'(r[0]) * 4 + $urandom_range(0, 11) - 2);
                1: io_addr = 16'(int'(r[1]) * 4 + $urandom_range(0, 11) - 2);
                2: io_addr = 16'(int'(cfg_sp_win[0]) * 4 + $urandom_range(0, 11) - 2);
                3: io_addr = 16'(int'(cfg_sp_win[1]) * 4 + $urandom_range(0, 11) - 2);
                default: io_addr = 16'($urandom);
            endcase
            io_valid = ($urandom_range(0, 7) != 0);
            apply_and_check();
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                fails++; tests++;
                $display("FAIL watchdog got=hung exp=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule